// File: doc/BRIEF.md
# Single-Transfer AHB-Lite Bus Master

This block turns simple commands from local logic into AHB-Lite transfers. A command gives a byte address, a direction, a transfer size and, for writes, the data. The master places the address and control signals on the bus in the address phase. It drives write data in the following data phase. It holds everything steady while the selected slave inserts wait states. When the data phase ends, it returns the read data and the slave's response on its command side with a one-cycle done strobe.

Only single transfers are issued. The transfer type is either idle or non-sequential. The burst type and the lock signal are fixed. A new command can enter its address phase in the same cycle as the previous command's data phase, so with a zero-wait slave one transfer completes every cycle. Sizes are byte, halfword and word. Any unaligned address is rounded down to the size boundary before it reaches the bus.

Top module: `ahbm_master`

## Requirements
- R1: While and after the active-low reset, `htrans` is 2'b00 (idle), `reqReady` is high and `rspDone` is low until a command is given.
- R2: `hburst` is always 3'b000, `hmastlock` is always low and `hprot` is always 4'b0011.
- R3: `htrans` is 2'b10 (non-sequential) in every cycle that an accepted command occupies the address phase, and 2'b00 otherwise. `hwrite` (1 = write, 0 = read) is presented with that address.
- R4: `hsize` is 3'b000 for byte, 3'b001 for halfword and 3'b010 for word. A command size above 3'b010 is issued as word. `haddr` equals the command address with bit 0 cleared for halfword, and bits 1:0 cleared for word.
- R5: A write's data appears on `hwdata` from the cycle after its address phase is accepted (`hready` high) until its data phase completes.
- R6: While `hready` is low, a pending address phase keeps `haddr`, `hsize`, `hwrite` and `htrans` unchanged. `hwdata` stays unchanged. `reqReady` is low whenever an address phase is pending and `hready` is low.
- R7: Read data is taken from `hrdata` in the cycle where `hready` is high during the data phase. It is shown on `rspRdata` with `rspDone` in the next cycle. `rspRdata` is zero for a write.
- R8: `hresp` is sampled when the data phase completes. `rspErr` is high together with `rspDone` exactly when that response was ERROR (1), and low otherwise.
- R9: `rspDone` pulses for one cycle per completed transfer, in command order. `rspErr` is never high without `rspDone`.
- R10: A command is accepted while the previous one is in its data phase. With a zero-wait slave, back-to-back commands complete on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A command is offered |
| reqReady | output | 1 | Command accepted at this edge when reqValid is high |
| reqAddr | input | 32 | Command byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 3 | 0 byte, 1 halfword, 2 word |
| reqWdata | input | 32 | Write data |
| rspDone | output | 1 | One-cycle completion strobe |
| rspErr | output | 1 | Completed transfer had an ERROR response |
| rspRdata | output | 32 | Read data of the completed read |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Burst type, fixed single |
| hprot | output | 4 | Protection, fixed |
| hmastlock | output | 1 | Lock, fixed low |
| hwdata | output | 32 | Bus write data |
| hready | input | 1 | Transfer-complete from the bus |
| hresp | input | 1 | Slave response, 1 = ERROR |
| hrdata | input | 32 | Bus read data |

## Verification
The two phase-valid flags are the core of the state. A stuck or wrongly set address-phase flag shows at once as a wrong `htrans` value or a missing `reqReady`. A wrong data-phase flag shows one cycle later as a missing, extra or misordered `rspDone`. Address or data registers that move during a wait state show as changed bus values in the very next stalled cycle. A data phase that is shifted by one cycle gives the slave the wrong `hwdata`, or returns read data that belongs to a neighbouring transfer. The scoreboard catches this at the next done strobe.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_NONSEQ = 2'b10
  } htrans_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAp;   // take a new command into the address phase
    logic advance;  // bus edge completes: address phase moves to data phase
    logic finish;   // a data phase completes at this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/ahbm_ctrl.sv
module ahbm_ctrl
  import ahbm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         hready,
  output logic         reqReady,
  output logic         apValid,
  output logic         rspDone,
  output ctrlStrobes_t strobes
);

  logic dpValid;

  // a slot opens when no address phase is pending or the pending one is taken
  assign reqReady        = !apValid || hready;
  assign strobes.loadAp  = reqValid && reqReady;
  assign strobes.advance = hready;
  assign strobes.finish  = hready && dpValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      apValid <= 1'b0;
      dpValid <= 1'b0;
      rspDone <= 1'b0;
    end else begin
      if (reqReady) apValid <= reqValid;
      if (hready)   dpValid <= apValid;
      rspDone <= hready && dpValid;
    end
  end

  // R6: a pending address phase survives a wait state
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (apValid && !hready) |=> apValid);

  // R10: an address phase taken by the bus becomes a data phase next cycle
  p_overlap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (apValid && hready) |=> dpValid);

  // R9: every done strobe comes from a completed data phase
  p_done_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> $past(dpValid && hready));

endmodule

// File: rtl/ahbm_datapath.sv
module ahbm_datapath
  import ahbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              apValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              hresp,
  input  logic [DATA_W-1:0] hrdata,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [DATA_W-1:0] hwdata,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int MAX_SZ = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] apAddr;
  logic              apWrite;
  logic [2:0]        apSize;
  logic [DATA_W-1:0] apWdata;
  logic              dpWrite;
  logic [DATA_W-1:0] hwdataQ;
  logic [2:0]        effSize;
  logic [ADDR_W-1:0] alignedAddr;

  // clamp the size to the bus width, then round the address down
  always_comb begin
    effSize     = (reqSize > 3'(MAX_SZ)) ? 3'(MAX_SZ) : reqSize;
    alignedAddr = reqAddr;
    for (int i = 0; i < MAX_SZ; i++) begin
      if (i < int'(effSize)) alignedAddr[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      apAddr  <= '0;
      apWrite <= 1'b0;
      apSize  <= SZ_BYTE;
      apWdata <= '0;
    end else if (strobes.loadAp) begin
      apAddr  <= alignedAddr;
      apWrite <= reqWrite;
      apSize  <= effSize;
      apWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpWrite <= 1'b0;
      hwdataQ <= '0;
    end else if (strobes.advance) begin
      dpWrite <= apValid && apWrite;
      if (apValid && apWrite) hwdataQ <= apWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspErr <= strobes.finish && hresp;
      if (strobes.finish) rspRdata <= dpWrite ? '0 : hrdata;
    end
  end

  assign haddr  = apAddr;
  assign hwrite = apWrite;
  assign hsize  = apSize;
  assign hwdata = hwdataQ;

  // R6: address-phase fields stay put while the bus is stalled
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.loadAp) |=>
      ($stable(apAddr) && $stable(apWrite) && $stable(apSize)));

  // R5: write data stays on the bus through a stalled data phase
  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(hwdataQ));

  // R4: a halfword address never has bit 0 set
  p_align_half_r4: assert property (@(posedge clk) disable iff (!rstN)
    (apSize == SZ_HALF) |-> !apAddr[0]);

endmodule

// File: rtl/ahbm_master.sv
module ahbm_master
  import ahbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic              hmastlock,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic [DATA_W-1:0] hrdata
);

  ctrlStrobes_t strobes;
  logic         apValid;
  htrans_e      transType;

  ahbm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .hready   (hready),
    .reqReady (reqReady),
    .apValid  (apValid),
    .rspDone  (rspDone),
    .strobes  (strobes)
  );

  ahbm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .apValid  (apValid),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqWdata (reqWdata),
    .hresp    (hresp),
    .hrdata   (hrdata),
    .haddr    (haddr),
    .hwrite   (hwrite),
    .hsize    (hsize),
    .hwdata   (hwdata),
    .rspErr   (rspErr),
    .rspRdata (rspRdata)
  );

  assign transType = apValid ? TR_NONSEQ : TR_IDLE;
  assign htrans    = transType;
  assign hburst    = 3'b000;
  assign hprot     = 4'b0011;
  assign hmastlock = 1'b0;

  // R8: an error flag only ever travels with a done strobe
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);

  // R3: a non-sequential transfer stays on the bus until the bus takes it
  p_trans_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b10));

endmodule

// File: tb/ahbm_master_bench.sv
module ahbm_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspDone, rspErr;
  logic [31:0] rspRdata;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic        hwrite, hmastlock, hready, hresp;
  logic [2:0]  hsize, hburst;
  logic [3:0]  hprot;

  always #2 clk = ~clk;

  ahbm_master u_ahbm_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hprot(hprot), .hmastlock(hmastlock), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycle = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct { logic err; logic wr; logic [31:0] rdata; } rsp_t;
  typedef struct { logic [31:0] addr; logic [2:0] size; logic wr; } ap_t;
  rsp_t        expQ[$];
  ap_t         apQ[$];
  logic [31:0] wQ[$];
  int          doneAt[$];
  logic [31:0] refMem [16];

  // ---------------- slave model ----------------
  int          waitCfg = 0;
  logic [31:0] mem [16];
  logic        dActive, dWrite, dErr;
  logic [31:0] dAddr;
  logic [3:0]  cnt;

  always_comb begin
    hrdata = mem[dAddr[5:2]];
    if (!dActive) begin
      hready = 1'b1; hresp = 1'b0;
    end else if (dErr) begin
      hresp = 1'b1; hready = (cnt != 4'd0);
    end else begin
      hresp = 1'b0; hready = (int'(cnt) >= waitCfg);
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dActive <= 1'b0; dWrite <= 1'b0; dErr <= 1'b0; dAddr <= '0; cnt <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i;
    end else if (hready) begin
      if (dActive && dWrite) begin
        if (wQ.size() == 0) check(0, "R5 unexpected write data", hwdata, 0);
        else begin
          logic [31:0] ew;
          ew = wQ.pop_front();
          check(hwdata == ew, "R5 hwdata in data phase", hwdata, ew);
        end
        if (!dErr) mem[dAddr[5:2]] <= hwdata;
      end
      if (htrans == 2'b10) begin
        if (apQ.size() == 0) check(0, "R3 unexpected address phase", haddr, 0);
        else begin
          ap_t ea;
          ea = apQ.pop_front();
          check(haddr == ea.addr, "R4 aligned haddr", haddr, ea.addr);
          check(hsize == ea.size, "R4 hsize code", {29'd0, hsize}, {29'd0, ea.size});
          check(hwrite == ea.wr, "R3 hwrite with address", {31'd0, hwrite}, {31'd0, ea.wr});
        end
      end
      dActive <= (htrans == 2'b10);
      dWrite  <= hwrite;
      dAddr   <= haddr;
      dErr    <= haddr[31];
      cnt     <= '0;
    end else begin
      cnt <= cnt + 4'd1;
    end
  end

  // ---------------- monitor ----------------
  logic        prevHready = 1'b1;
  logic [1:0]  prevTrans = 2'b00;
  logic [31:0] prevAddr = '0, prevWdata = '0;
  logic        prevWrite = 1'b0;
  logic [2:0]  prevSize = '0;

  always @(negedge clk) begin
    cycle++;
    if (rstN && !finished) begin
      if (rspDone) begin
        doneAt.push_back(cycle);
        if (expQ.size() == 0) check(0, "R9 extra done strobe", 1, 0);
        else begin
          rsp_t e;
          e = expQ.pop_front();
          check(rspErr == e.err, "R8 response flag", {31'd0, rspErr}, {31'd0, e.err});
          if (!e.err) check(rspRdata == e.rdata, "R7 returned data", rspRdata, e.rdata);
        end
      end else begin
        check(!rspErr, "R9 error without done", {31'd0, rspErr}, 0);
      end
      if (htrans == 2'b10)
        check(hburst == 3'b000 && hmastlock == 1'b0 && hprot == 4'b0011,
              "R2 fixed controls", {24'd0, hprot, hburst, hmastlock}, 32'h0000_0030);
      if (!prevHready && prevTrans == 2'b10)
        check(haddr == prevAddr && htrans == prevTrans && hwrite == prevWrite && hsize == prevSize,
              "R6 address held in wait", haddr, prevAddr);
      if (!prevHready)
        check(hwdata == prevWdata, "R6 hwdata held in wait", hwdata, prevWdata);
      if (!hready && htrans == 2'b10)
        check(!reqReady, "R6 ready low while stalled", {31'd0, reqReady}, 0);
    end
    prevHready = hready; prevTrans = htrans; prevAddr = haddr;
    prevWrite = hwrite; prevSize = hsize; prevWdata = hwdata;
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [31:0] a, input bit wr, input logic [2:0] sz, input logic [31:0] wd);
    logic [2:0]  es;
    logic [31:0] ea;
    rsp_t        r;
    ap_t         p;
    es = (sz > 3'd2) ? 3'd2 : sz;
    ea = a;
    if (es >= 3'd1) ea[0] = 1'b0;
    if (es == 3'd2) ea[1] = 1'b0;
    r.err = a[31]; r.wr = wr; r.rdata = wr ? 32'd0 : refMem[ea[5:2]];
    if (wr && !a[31]) refMem[ea[5:2]] = wd;
    p.addr = ea; p.size = es; p.wr = wr;
    expQ.push_back(r);
    apQ.push_back(p);
    if (wr) wQ.push_back(wd);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqSize = sz; reqWdata = wd;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((expQ.size() != 0 || apQ.size() != 0) && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(expQ.size() == 0, "R9 all transfers completed", expQ.size(), 0);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 16; i++) refMem[i] = 32'hA000_0000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(htrans == 2'b00, "R1 idle htrans in reset", {30'd0, htrans}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(htrans == 2'b00, "R1 idle htrans after reset", {30'd0, htrans}, 0);
    check(reqReady == 1'b1, "R1 ready after reset", {31'd0, reqReady}, 1);
    check(rspDone == 1'b0, "R1 no done after reset", {31'd0, rspDone}, 0);

    // zero-wait back-to-back: R10
    waitCfg = 0;
    base = doneAt.size();
    issue(32'h0000_0000, 1, 3'd2, 32'h1111_2222);
    issue(32'h0000_0004, 1, 3'd2, 32'h3333_4444);
    issue(32'h0000_0000, 0, 3'd2, 0);
    issue(32'h0000_0004, 0, 3'd2, 0);
    idle();
    drain();
    check(doneAt.size() == base + 4, "R10 four completions", doneAt.size() - base, 4);
    if (doneAt.size() == base + 4)
      check(doneAt[base+3] - doneAt[base] == 3, "R10 consecutive completions",
            doneAt[base+3] - doneAt[base], 3);

    // wait states, sizes and rounding: R4, R5, R6, R7
    waitCfg = 2;
    issue(32'h0000_0007, 1, 3'd1, 32'hCAFE_0007);
    issue(32'h0000_000B, 0, 3'd3, 0);
    issue(32'h0000_0013, 1, 3'd0, 32'h0000_00AB);
    issue(32'h0000_0004, 0, 3'd1, 0);
    issue(32'h0000_0013, 0, 3'd0, 0);
    idle();
    drain();

    // error responses mixed with normal ones: R8
    waitCfg = 1;
    issue(32'h8000_0000, 0, 3'd2, 0);
    issue(32'h8000_0004, 1, 3'd2, 32'hDEAD_BEEF);
    issue(32'h0000_0008, 0, 3'd2, 0);
    idle();
    drain();

    // single isolated transfer with long wait, then idle again: R1, R3
    waitCfg = 3;
    issue(32'h0000_003C, 1, 3'd2, 32'h5A5A_A5A5);
    idle();
    issue(32'h0000_003C, 0, 3'd2, 0);
    idle();
    drain();
    @(negedge clk);
    check(htrans == 2'b00, "R3 idle when nothing pending", {30'd0, htrans}, 0);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule